// File: doc/BRIEF.md
# Transmit Abort and Completion Supervisor

This block watches over a single transmit request. The request starts when software pulses a set strobe. It ends in one of three ways: the MAC transmit engine reports that the frame is complete, a fault forces an abort, or software cancels the request. On an abort the block records which fault caused it. It clears the request bit and sets sticky flags for abort, transmit error and transmit done. It also issues a one-cycle command to write a status vector at the address just past the end of the packet. It never restarts the frame by itself.

Five faults can abort a frame:
- too many collisions;
- a collision beyond the collision window;
- a collision after 64 bytes;
- the deferral limit;
- an oversized frame.

The first four come from a shared medium. In full duplex they are ignored, so only the length fault can abort there. A gated interrupt line combines the error and done flags. Each term needs its own enable and the global enable.

Top module: `tx_abort_status`

## Requirements
- R1: A one-cycle `sw_req_set` while idle makes `req_active` 1 from the next rising edge. A `sw_req_set` while `req_active` is 1 has no effect.
- R2: In half duplex, each `ev_collision` during a request counts one retry. The counter is cleared when a request starts. The collision whose count (1-based) exceeds `retry_max` aborts the frame. With `retry_max`=0 the first collision aborts.
- R3: In half duplex, a collision with `coll_pos` > `coll_window` aborts the frame. A collision with `coll_pos` >= 64 aborts the frame and also sets `late_flag`. A collision that meets neither test leaves `late_flag` at 0.
- R4: In half duplex, `ev_defer_limit` aborts the frame when `defer_forever` is 0. When `defer_forever` is 1 it has no effect.
- R5: The length test uses the values present when the request starts. If `frame_len` > `max_len` and neither `huge_en` nor (`pkt_override` and `pkt_huge`) is 1, the frame aborts at the second rising edge after the set strobe.
- R6: With `full_duplex`=1, `ev_collision` and `ev_defer_limit` have no effect. The length test still applies.
- R7: An abort clears `req_active` and sets `abort_flag`, `txerr_flag` and `txdone_flag` at the same edge. After that, `req_active` stays 0 until the next `sw_req_set`.
- R8: `stv_we` pulses for one cycle at the edge where a request ends by abort or by `ev_tx_done`. With it, `stv_addr` = `pkt_end`+1 (wrapping) and `stv_data` gives the end cause. The bits of `stv_data` are:
  - bit0: success;
  - bit1: too many retries;
  - bit2: collision beyond the window;
  - bit3: collision at or after 64 bytes;
  - bit4: deferral limit;
  - bit5: oversized frame.
- R9: A `sw_req_clr` during a request, with no abort and no `ev_tx_done` in that cycle, ends the request. It sets `txdone_flag` but not `txerr_flag`, and no `stv_we` is issued. Priority is abort, then completion, then cancel. A `sw_req_clr` while idle has no effect.
- R10: The four flags stay set until their own clear strobe or reset. If a set and a clear arrive in the same cycle, the flag is set.
- R11: `irq` = `ie_global` and ((`ie_txerr` and `txerr_flag`) or (`ie_txdone` and `txdone_flag`)). It is registered at the same edge as the flags.
- R12: Engine events (`ev_collision`, `ev_defer_limit`, `ev_tx_done`) arriving while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req_set | input | 1 | Software strobe that sets the request bit |
| sw_req_clr | input | 1 | Software write of 0 to the request bit |
| sw_clr_abort | input | 1 | Clears the abort flag |
| sw_clr_late | input | 1 | Clears the late-collision flag |
| sw_clr_txerr | input | 1 | Clears the transmit-error flag |
| sw_clr_txdone | input | 1 | Clears the transmit-done flag |
| ie_global | input | 1 | Global interrupt enable |
| ie_txerr | input | 1 | Transmit-error interrupt enable |
| ie_txdone | input | 1 | Transmit-done interrupt enable |
| full_duplex | input | 1 | 1 selects full duplex |
| retry_max | input | RETRY_W | Maximum number of retries |
| coll_window | input | POS_W | Collision window, in bytes |
| defer_forever | input | 1 | 1 disables the deferral-limit abort |
| max_len | input | LEN_W | Maximum frame length |
| huge_en | input | 1 | Global permission for frames longer than `max_len` |
| pkt_override | input | 1 | Per-packet override valid |
| pkt_huge | input | 1 | Per-packet permission for frames longer than `max_len` |
| frame_len | input | LEN_W | Length of the requested frame |
| pkt_end | input | ADDR_W | Buffer address of the last byte of the packet |
| ev_collision | input | 1 | Collision event from the engine |
| coll_pos | input | POS_W | Bytes sent when the collision occurred |
| ev_defer_limit | input | 1 | Engine reached its deferral limit |
| ev_tx_done | input | 1 | Engine finished the frame |
| req_active | output | 1 | Request bit |
| abort_flag | output | 1 | Sticky abort status |
| late_flag | output | 1 | Sticky late-collision status |
| txerr_flag | output | 1 | Sticky transmit-error flag |
| txdone_flag | output | 1 | Sticky transmit-done flag |
| irq | output | 1 | Gated interrupt |
| stv_we | output | 1 | Status vector write command |
| stv_addr | output | ADDR_W | Status vector address |
| stv_data | output | 6 | Status vector cause bits |

## Verification
`req_active` rises at the first rising edge after the set strobe. An abort caused by a collision, a deferral event, the engine's done event or a cancel shows its result at the edge that samples the input. That result covers the request bit, all four flags, `irq`, and the status vector command. An oversize abort shows one edge later, because the length test is captured when the request starts.

The bench drives inputs on the falling edge. A behavioural model steps at the rising edge, and the outputs are compared with it at the next falling edge. Every result is therefore checked in exactly the cycle it is due. `stv_addr` and `stv_data` are compared only while `stv_we` is high.

// File: rtl/tas_pkg.sv
package tas_pkg;
  // Individual abort reasons for one transmit request.
  typedef struct packed {
    logic oversize;
    logic defer;
    logic late;
    logic window;
    logic excess;
  } tas_cause_t;

  localparam int STV_W = 6;
  localparam int NFLAG = 4;
  localparam int FL_ABORT  = 0;
  localparam int FL_LATE   = 1;
  localparam int FL_TXERR  = 2;
  localparam int FL_TXDONE = 3;
endpackage

// File: rtl/tas_classify.sv
module tas_classify
  import tas_pkg::*;
#(
  parameter int POS_W      = 16,
  parameter int LEN_W      = 16,
  parameter int RETRY_W    = 4,
  parameter int LATE_BYTES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic               start,
  input  logic               full_duplex,
  input  logic               ev_collision,
  input  logic [POS_W-1:0]   coll_pos,
  input  logic [POS_W-1:0]   coll_window,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic               ev_defer_limit,
  input  logic               defer_forever,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [LEN_W-1:0]   max_len,
  input  logic               huge_en,
  input  logic               pkt_override,
  input  logic               pkt_huge,
  output tas_cause_t         cause,
  output logic               abort
);
  localparam logic [POS_W-1:0] LATE_POS = POS_W'(LATE_BYTES);

  logic [RETRY_W-1:0] retry_cnt;
  logic               ovs_pend;
  logic               shared_ok;
  logic               coll_hd;
  logic [RETRY_W:0]   cnt_next;
  logic               too_long;
  logic               long_allowed;

  // Collision and deferral faults only exist on a shared medium.
  assign shared_ok    = active & ~full_duplex;
  assign coll_hd      = shared_ok & ev_collision;
  assign cnt_next     = {1'b0, retry_cnt} + 1'b1;
  assign too_long     = frame_len > max_len;
  assign long_allowed = huge_en | (pkt_override & pkt_huge);

  always_ff @(posedge clk) begin
    if (rst) begin
      retry_cnt <= '0;
      ovs_pend  <= 1'b0;
    end else if (start) begin
      retry_cnt <= '0;
      ovs_pend  <= too_long & ~long_allowed;
    end else if (coll_hd) begin
      retry_cnt <= cnt_next[RETRY_W-1:0];
    end
  end

  always_comb begin
    cause.excess   = coll_hd & (cnt_next > {1'b0, retry_max});
    cause.window   = coll_hd & (coll_pos > coll_window);
    cause.late     = coll_hd & (coll_pos >= LATE_POS);
    cause.defer    = shared_ok & ev_defer_limit & ~defer_forever;
    cause.oversize = active & ovs_pend;
    abort          = |cause;
  end
endmodule

// File: rtl/tas_req_ctrl.sv
module tas_req_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sw_req_set,
  input  logic sw_req_clr,
  input  logic ev_tx_done,
  input  logic abort,
  output logic active,
  output logic start,
  output logic end_abort,
  output logic end_done,
  output logic end_cancel
);
  logic finish;

  // Priority of the end causes: abort, then completion, then cancel.
  assign start      = ~active & sw_req_set;
  assign end_abort  = active & abort;
  assign end_done   = active & ~abort & ev_tx_done;
  assign end_cancel = active & ~abort & ~ev_tx_done & sw_req_clr;
  assign finish     = end_abort | end_done | end_cancel;

  always_ff @(posedge clk) begin
    if (rst)         active <= 1'b0;
    else if (finish) active <= 1'b0;
    else if (start)  active <= 1'b1;
  end
endmodule

// File: rtl/tas_flags.sv
module tas_flags
  import tas_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  input  logic             ie_global,
  input  logic             ie_txerr,
  input  logic             ie_txdone,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic [NFLAG-1:0] flag_nxt;

  // One sticky bit per flag; a set in the same cycle beats a clear.
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_nxt[i] = set_vec[i] | (flags[i] & ~clr_vec[i]);
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= flag_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ie_global & ((ie_txerr & flag_nxt[FL_TXERR]) |
                                 (ie_txdone & flag_nxt[FL_TXDONE]));
  end
endmodule

// File: rtl/tas_stv.sv
module tas_stv
  import tas_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              end_abort,
  input  logic              end_done,
  input  tas_cause_t        cause,
  input  logic [ADDR_W-1:0] pkt_end,
  output logic              stv_we,
  output logic [ADDR_W-1:0] stv_addr,
  output logic [STV_W-1:0]  stv_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stv_we   <= 1'b0;
      stv_addr <= '0;
      stv_data <= '0;
    end else begin
      stv_we <= end_abort | end_done;
      if (end_abort | end_done) begin
        stv_addr <= pkt_end + 1'b1;
        stv_data <= {cause.oversize, cause.defer, cause.late,
                     cause.window, cause.excess, end_done};
      end
    end
  end
endmodule

// File: rtl/tx_abort_status.sv
module tx_abort_status
  import tas_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int LEN_W      = 16,
  parameter int POS_W      = 16,
  parameter int RETRY_W    = 4,
  parameter int LATE_BYTES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_req_set,
  input  logic               sw_req_clr,
  input  logic               sw_clr_abort,
  input  logic               sw_clr_late,
  input  logic               sw_clr_txerr,
  input  logic               sw_clr_txdone,
  input  logic               ie_global,
  input  logic               ie_txerr,
  input  logic               ie_txdone,
  input  logic               full_duplex,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic [POS_W-1:0]   coll_window,
  input  logic               defer_forever,
  input  logic [LEN_W-1:0]   max_len,
  input  logic               huge_en,
  input  logic               pkt_override,
  input  logic               pkt_huge,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [ADDR_W-1:0]  pkt_end,
  input  logic               ev_collision,
  input  logic [POS_W-1:0]   coll_pos,
  input  logic               ev_defer_limit,
  input  logic               ev_tx_done,
  output logic               req_active,
  output logic               abort_flag,
  output logic               late_flag,
  output logic               txerr_flag,
  output logic               txdone_flag,
  output logic               irq,
  output logic               stv_we,
  output logic [ADDR_W-1:0]  stv_addr,
  output logic [STV_W-1:0]   stv_data
);
  tas_cause_t       cause;
  logic             abort;
  logic             start;
  logic             end_abort;
  logic             end_done;
  logic             end_cancel;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] flags;

  tas_req_ctrl u_req (
    .clk        (clk),
    .rst        (rst),
    .sw_req_set (sw_req_set),
    .sw_req_clr (sw_req_clr),
    .ev_tx_done (ev_tx_done),
    .abort      (abort),
    .active     (req_active),
    .start      (start),
    .end_abort  (end_abort),
    .end_done   (end_done),
    .end_cancel (end_cancel)
  );

  tas_classify #(
    .POS_W      (POS_W),
    .LEN_W      (LEN_W),
    .RETRY_W    (RETRY_W),
    .LATE_BYTES (LATE_BYTES)
  ) u_cls (
    .clk            (clk),
    .rst            (rst),
    .active         (req_active),
    .start          (start),
    .full_duplex    (full_duplex),
    .ev_collision   (ev_collision),
    .coll_pos       (coll_pos),
    .coll_window    (coll_window),
    .retry_max      (retry_max),
    .ev_defer_limit (ev_defer_limit),
    .defer_forever  (defer_forever),
    .frame_len      (frame_len),
    .max_len        (max_len),
    .huge_en        (huge_en),
    .pkt_override   (pkt_override),
    .pkt_huge       (pkt_huge),
    .cause          (cause),
    .abort          (abort)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FL_ABORT]  = end_abort;
    set_vec[FL_LATE]   = end_abort & cause.late;
    set_vec[FL_TXERR]  = end_abort;
    set_vec[FL_TXDONE] = end_abort | end_done | end_cancel;
    clr_vec            = '0;
    clr_vec[FL_ABORT]  = sw_clr_abort;
    clr_vec[FL_LATE]   = sw_clr_late;
    clr_vec[FL_TXERR]  = sw_clr_txerr;
    clr_vec[FL_TXDONE] = sw_clr_txdone;
  end

  tas_flags u_flg (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .ie_global (ie_global),
    .ie_txerr  (ie_txerr),
    .ie_txdone (ie_txdone),
    .flags     (flags),
    .irq       (irq)
  );

  assign abort_flag  = flags[FL_ABORT];
  assign late_flag   = flags[FL_LATE];
  assign txerr_flag  = flags[FL_TXERR];
  assign txdone_flag = flags[FL_TXDONE];

  tas_stv #(.ADDR_W(ADDR_W)) u_stv (
    .clk       (clk),
    .rst       (rst),
    .end_abort (end_abort),
    .end_done  (end_done),
    .cause     (cause),
    .pkt_end   (pkt_end),
    .stv_we    (stv_we),
    .stv_addr  (stv_addr),
    .stv_data  (stv_data)
  );
endmodule

// File: rtl/tas_checker.sv
module tas_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_req_set,
  input logic              full_duplex,
  input logic              ie_global,
  input logic [ADDR_W-1:0] pkt_end,
  input logic              req_active,
  input logic              abort_flag,
  input logic              late_flag,
  input logic              txerr_flag,
  input logic              txdone_flag,
  input logic              irq,
  input logic              stv_we,
  input logic [ADDR_W-1:0] stv_addr
);
  AST_REQ_NEEDS_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(req_active) |-> $past(sw_req_set)); // R1

  AST_LATE_WITH_ABORT: assert property (@(posedge clk) disable iff (rst)
    $rose(late_flag) |-> abort_flag && !req_active); // R3

  AST_FD_NO_LATE: assert property (@(posedge clk) disable iff (rst)
    $rose(late_flag) |-> !$past(full_duplex)); // R6

  AST_ERR_SET_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(txerr_flag) |-> abort_flag && txdone_flag && !req_active); // R7

  AST_STV_AT_END: assert property (@(posedge clk) disable iff (rst)
    stv_we |-> $past(req_active) && !req_active); // R8

  AST_STV_ADDR: assert property (@(posedge clk) disable iff (rst)
    stv_we |-> stv_addr == ADDR_W'($past(pkt_end) + 1'b1)); // R8

  AST_STV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stv_we |=> !stv_we); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie_global)); // R11
endmodule

bind tx_abort_status tas_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sw_req_set  (sw_req_set),
  .full_duplex (full_duplex),
  .ie_global   (ie_global),
  .pkt_end     (pkt_end),
  .req_active  (req_active),
  .abort_flag  (abort_flag),
  .late_flag   (late_flag),
  .txerr_flag  (txerr_flag),
  .txdone_flag (txdone_flag),
  .irq         (irq),
  .stv_we      (stv_we),
  .stv_addr    (stv_addr)
);

// File: tb/tb_tx_abort_status.sv
`timescale 1ns/1ps
module tb_tx_abort_status;
  localparam int ADDR_W = 13;
  localparam int LEN_W  = 16;
  localparam int POS_W  = 16;
  localparam int RW     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_req_set = 0, sw_req_clr = 0;
  logic sw_clr_abort = 0, sw_clr_late = 0, sw_clr_txerr = 0, sw_clr_txdone = 0;
  logic ie_global = 0, ie_txerr = 0, ie_txdone = 0;
  logic full_duplex = 0, defer_forever = 0;
  logic [RW-1:0] retry_max = 4'd2;
  logic [POS_W-1:0] coll_window = 16'd50, coll_pos = 16'd0;
  logic [LEN_W-1:0] max_len = 16'd1518, frame_len = 16'd100;
  logic huge_en = 0, pkt_override = 0, pkt_huge = 0;
  logic [ADDR_W-1:0] pkt_end = 13'h0100;
  logic ev_collision = 0, ev_defer_limit = 0, ev_tx_done = 0;
  logic req_active, abort_flag, late_flag, txerr_flag, txdone_flag, irq, stv_we;
  logic [ADDR_W-1:0] stv_addr;
  logic [5:0] stv_data;

  tx_abort_status dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string scen = "R1";

  // behavioural reference state
  logic m_act = 0, m_ovr = 0, m_ab = 0, m_lt = 0, m_er = 0, m_dn = 0, m_irq = 0, m_we = 0;
  int m_cnt = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [5:0] m_data = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", scen, tag, act, exp);
    end
  endtask

  task automatic model_tick();
    bit hd, coll, exc, win, lt, df, ov, ab, dn, cn;
    if (rst) begin
      m_act = 0; m_ovr = 0; m_ab = 0; m_lt = 0; m_er = 0; m_dn = 0;
      m_irq = 0; m_we = 0; m_cnt = 0; m_addr = '0; m_data = '0;
      return;
    end
    hd   = m_act && !full_duplex;
    coll = hd && ev_collision;
    exc  = coll && (m_cnt + 1 > int'(retry_max));
    win  = coll && (int'(coll_pos) > int'(coll_window));
    lt   = coll && (int'(coll_pos) >= 64);
    df   = hd && ev_defer_limit && !defer_forever;
    ov   = m_act && m_ovr;
    ab   = exc || win || lt || df || ov;
    dn   = m_act && !ab && ev_tx_done;
    cn   = m_act && !ab && !dn && sw_req_clr;
    if (!m_act && sw_req_set) begin
      m_cnt = 0;
      m_ovr = (int'(frame_len) > int'(max_len)) && !(huge_en || (pkt_override && pkt_huge));
      m_act = 1;
    end else if (ab || dn || cn) begin
      m_act = 0;
    end else if (coll) begin
      m_cnt++;
    end
    m_ab = ab || (m_ab && !sw_clr_abort);
    m_lt = (ab && lt) || (m_lt && !sw_clr_late);
    m_er = ab || (m_er && !sw_clr_txerr);
    m_dn = ab || dn || cn || (m_dn && !sw_clr_txdone);
    m_irq = ie_global && ((ie_txerr && m_er) || (ie_txdone && m_dn));
    m_we = ab || dn;
    if (m_we) begin
      m_addr = pkt_end + 1'b1;
      m_data = {ov, df, lt, win, exc, dn};
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    chk("R1 req_active", 32'(req_active), 32'(m_act));
    chk("R7 abort_flag", 32'(abort_flag), 32'(m_ab));
    chk("R3 late_flag", 32'(late_flag), 32'(m_lt));
    chk("R7 txerr_flag", 32'(txerr_flag), 32'(m_er));
    chk("R9 txdone_flag", 32'(txdone_flag), 32'(m_dn));
    chk("R11 irq", 32'(irq), 32'(m_irq));
    chk("R8 stv_we", 32'(stv_we), 32'(m_we));
    if (m_we) begin
      chk("R8 stv_addr", 32'(stv_addr), 32'(m_addr));
      chk("R8 stv_data", 32'(stv_data), 32'(m_data));
    end
    sw_req_set = 0; sw_req_clr = 0; ev_collision = 0; ev_defer_limit = 0; ev_tx_done = 0;
    sw_clr_abort = 0; sw_clr_late = 0; sw_clr_txerr = 0; sw_clr_txdone = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clear_all();
    sw_clr_abort = 1; sw_clr_late = 1; sw_clr_txerr = 1; sw_clr_txdone = 1;
    step();
  endtask

  task automatic start_req();
    sw_req_set = 1; step();
  endtask

  task automatic collide(input int pos);
    ev_collision = 1; coll_pos = POS_W'(pos); step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    idle(3);
    rst = 0;
    scen = "R1"; idle(1);
    // R1 normal success and set while active ignored
    start_req(); idle(2); sw_req_set = 1; step();
    ev_tx_done = 1; step(); idle(1);
    chk("R1 done ok bit0", 32'(stv_data), 32'h01);
    clear_all();
    // R2 retries
    scen = "R2";
    start_req(); collide(10); collide(10); collide(10); idle(2);
    clear_all();
    retry_max = 0; start_req(); collide(5); idle(1); retry_max = 2;
    clear_all();
    // R3 window and late
    scen = "R3";
    start_req(); collide(60); idle(1); clear_all();
    start_req(); collide(70); idle(1); clear_all();
    start_req(); collide(50); ev_tx_done = 1; step(); clear_all();
    // R4 defer
    scen = "R4";
    defer_forever = 1; start_req(); ev_defer_limit = 1; step(); ev_tx_done = 1; step();
    defer_forever = 0; clear_all();
    start_req(); ev_defer_limit = 1; step(); clear_all();
    // R5 oversize
    scen = "R5";
    frame_len = 16'd2000; start_req(); idle(3); clear_all();
    huge_en = 1; start_req(); idle(1); ev_tx_done = 1; step(); huge_en = 0; clear_all();
    pkt_override = 1; pkt_huge = 1; start_req(); ev_tx_done = 1; step(); clear_all();
    pkt_huge = 0; start_req(); idle(2); pkt_override = 0; clear_all();
    frame_len = 16'd1518; start_req(); ev_tx_done = 1; step(); clear_all();
    frame_len = 16'd100;
    // R6 full duplex
    scen = "R6";
    full_duplex = 1; start_req(); collide(70); ev_defer_limit = 1; step();
    ev_tx_done = 1; step(); clear_all();
    frame_len = 16'd3000; start_req(); idle(2); clear_all();
    frame_len = 16'd100; full_duplex = 0;
    // R9 cancel
    scen = "R9";
    start_req(); sw_req_clr = 1; step(); idle(1); clear_all();
    sw_req_clr = 1; step();
    start_req(); sw_req_clr = 1; ev_tx_done = 1; step(); clear_all();
    start_req(); sw_req_clr = 1; ev_defer_limit = 1; step(); clear_all();
    // R10 sticky and set-beats-clear
    scen = "R10";
    start_req(); collide(80); idle(3);
    sw_clr_late = 1; step(); sw_clr_abort = 1; step(); sw_clr_txerr = 1; step();
    sw_clr_txdone = 1; step();
    start_req(); sw_clr_txerr = 1; sw_clr_txdone = 1; sw_clr_abort = 1;
    ev_defer_limit = 1; step(); clear_all();
    // R11 interrupt gating
    scen = "R11";
    start_req(); collide(90); idle(1);
    ie_txerr = 1; step(); ie_global = 1; step(); ie_txerr = 0; step();
    ie_txdone = 1; step(); sw_clr_txdone = 1; step();
    ie_txerr = 1; step(); ie_global = 0; step(); clear_all();
    ie_global = 1; start_req(); ev_tx_done = 1; step(); idle(1);
    ie_global = 0; ie_txerr = 0; ie_txdone = 0; clear_all();
    // R12 events while idle
    scen = "R12";
    collide(90); ev_defer_limit = 1; step(); ev_tx_done = 1; step(); idle(1);
    // R8 address wrap
    scen = "R8";
    pkt_end = '1; start_req(); ev_tx_done = 1; step(); idle(1);
    pkt_end = 13'h0abc; start_req(); collide(100); idle(1);
    clear_all(); idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule